// File: doc/BRIEF.md
# Panel Serial Command Sequencer

This block configures a display panel over a three-wire, write-only command port made of an active-low select, a serial clock and a serial data line. It stores two fixed scripts of register writes. The power-up script brings the panel into operation, and the power-down script puts it to sleep. A one-cycle request on either start input plays the whole chosen script. Each entry goes out as one 16-bit frame: the register address sits in the upper byte and the data byte in the lower byte, and the most significant bit is sent first.

All waits are counted in microsecond ticks. A divider produces one tick every `CLKS_PER_US` clocks, and each wait restarts the divider, so every phase lasts exactly a whole number of ticks. The setup wait, the bit half-period and the gap between frames are parameters in microseconds. The panel interface mode code (8-bit serial RGB, `8'hC9`) is a parameter for the integrator's reference and is never sent.

Top module: `pnl_cmd_seq`

## Requirements
- R1: During reset and whenever `busy` is low, `sel_n` is 1, `sclk` is 1 and `sdat` is 0.
- R2: Each frame is 16 bits: the address is in bits 15..8 and the data in bits 7..0, sent MSB first. The panel takes each bit on a rising `sclk` while `sel_n` is 0, and `sclk` rises exactly 16 times per frame.
- R3: `sel_n` falls at the start of a frame, and the first falling edge of `sclk` follows exactly `SETUP_US` ticks later.
- R4: Each bit places its value on `sdat` as `sclk` falls. `sclk` then stays low for `HALF_US` ticks and high for `HALF_US` ticks, and `sdat` does not change while `sclk` is high.
- R5: `sel_n` rises `HALF_US` ticks after the 16th rising edge of `sclk`. The next `sel_n` falling edge comes no sooner than `GAP_US` ticks after that.
- R6: The power-up script (`start_up`) sends, in this order: 0x05/0x1E, 0x05/0xC6, 0x07/0x8D, 0x13/0x01, 0x05/0xC7.
- R7: The power-down script (`start_down`) sends the single frame 0x05/0x5E.
- R8: The mode value `MODE_CODE` (0xC9) is never sent as an address byte or as a data byte.
- R9: `busy` goes high on the clock edge that accepts a start and stays high until the last gap has ended. At that point `done` pulses high for exactly one cycle, in the first cycle where `busy` is low.
- R10: A start request that arrives while `busy` is high is ignored. The script that is running plays unchanged, and no extra frames follow it.
- R11: If `start_up` and `start_down` are both high in the same idle cycle, the power-down script plays.
- R12: A tick lasts `CLKS_PER_US` clocks, so every phase in clock cycles equals its length in ticks times `CLKS_PER_US`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_up | input | 1 | Request to play the power-up script |
| start_down | input | 1 | Request to play the power-down script |
| sel_n | output | 1 | Serial command select, active low |
| sclk | output | 1 | Serial command clock |
| sdat | output | 1 | Serial command data |
| busy | output | 1 | A script is being played |
| done | output | 1 | One-cycle pulse when a script has finished |

## Verification
The hardest conditions to create from the ports are start requests that land while a script is running, and a request on both inputs in the same idle cycle. Only a run of back-to-back scripts with well-placed pulses reaches them. The bench plays directed runs first: power-up, then power-down, then both inputs together, then power-up with pulses of both kinds injected in the middle. It then plays seeded random runs that vary the choice of script, the idle time before it and the number of stray pulses during it. A monitor rebuilds every frame from the pins, measures every phase in cycles against the tick arithmetic, and compares the frames it collects with the script the bench expects.

// File: rtl/pnl_pkg.sv
package pnl_pkg;

  typedef struct packed {
    logic load;     // take a new frame word into the shifter
    logic csLow;    // open a frame
    logic sclLow;   // present the current bit, clock low
    logic sclHigh;  // clock high, advance the shifter
    logic csHigh;   // close the frame
  } pnl_strb_t;

  // Number of frames in a script; sel=1 is power-down.
  function automatic logic [2:0] scriptLen(input logic sel);
    return sel ? 3'd1 : 3'd5;
  endfunction

  // Frame word {address, data} of entry idx of a script.
  function automatic logic [15:0] scriptWord(input logic sel, input logic [2:0] idx);
    logic [15:0] w;
    if (sel) begin
      w = 16'h055E;
    end else begin
      case (idx)
        3'd0:    w = 16'h051E;
        3'd1:    w = 16'h05C6;
        3'd2:    w = 16'h078D;
        3'd3:    w = 16'h1301;
        default: w = 16'h05C7;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/pnl_tick.sv
module pnl_tick #(
  parameter int unsigned CLKS_PER_US = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (restart)      cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  generate
    if (CLKS_PER_US > 1) begin : g_chk
      // R12: ticks are spaced by the divider, never back to back
      p_tick_spaced_r12: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pnl_ctrl.sv
module pnl_ctrl
  import pnl_pkg::*;
#(
  parameter int unsigned SETUP_US = 25,
  parameter int unsigned HALF_US  = 25,
  parameter int unsigned GAP_US   = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startUp,
  input  logic        startDown,
  input  logic        tick,
  output logic        restart,
  output pnl_strb_t   strb,
  output logic [15:0] frameWord,
  output logic        busy,
  output logic        done
);
  localparam int unsigned MAXA = (SETUP_US > HALF_US) ? SETUP_US : HALF_US;
  localparam int unsigned MAXD = (MAXA > GAP_US) ? MAXA : GAP_US;
  localparam int unsigned TW   = $clog2(MAXD + 1);
  localparam logic [TW-1:0] SETUP_LAST = TW'(SETUP_US - 1);
  localparam logic [TW-1:0] HALF_LAST  = TW'(HALF_US - 1);
  localparam logic [TW-1:0] GAP_LAST   = TW'(GAP_US - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_BLO, ST_BHI, ST_GAP} state_t;

  state_t        state, nState;
  logic          scriptSel, nSel;
  logic [2:0]    idx, nIdx;
  logic [3:0]    bitCnt, nBit;
  logic [TW-1:0] tickCnt;
  logic [TW-1:0] phaseLast;
  logic          phaseEnd;
  logic          doneNext;

  always_comb begin
    case (state)
      ST_SETUP:        phaseLast = SETUP_LAST;
      ST_BLO, ST_BHI:  phaseLast = HALF_LAST;
      default:         phaseLast = GAP_LAST;
    endcase
  end

  assign phaseEnd = tick && (tickCnt == phaseLast);

  always_comb begin
    nState   = state;
    nSel     = scriptSel;
    nIdx     = idx;
    nBit     = bitCnt;
    strb     = '0;
    restart  = 1'b0;
    doneNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startUp || startDown) begin
          nSel       = startDown;   // power-down wins a tie
          nIdx       = '0;
          strb.load  = 1'b1;
          strb.csLow = 1'b1;
          restart    = 1'b1;
          nState     = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (phaseEnd) begin
          strb.sclLow = 1'b1;
          nBit        = '0;
          restart     = 1'b1;
          nState      = ST_BLO;
        end
      end
      ST_BLO: begin
        if (phaseEnd) begin
          strb.sclHigh = 1'b1;
          restart      = 1'b1;
          nState       = ST_BHI;
        end
      end
      ST_BHI: begin
        if (phaseEnd) begin
          restart = 1'b1;
          if (bitCnt == 4'd15) begin
            strb.csHigh = 1'b1;
            nState      = ST_GAP;
          end else begin
            strb.sclLow = 1'b1;
            nBit        = bitCnt + 1'b1;
            nState      = ST_BLO;
          end
        end
      end
      default: begin
        if (phaseEnd) begin
          if (idx == scriptLen(scriptSel) - 3'd1) begin
            doneNext = 1'b1;
            nState   = ST_IDLE;
          end else begin
            nIdx       = idx + 1'b1;
            strb.load  = 1'b1;
            strb.csLow = 1'b1;
            restart    = 1'b1;
            nState     = ST_SETUP;
          end
        end
      end
    endcase
  end

  assign frameWord = scriptWord(nSel, nIdx);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      scriptSel <= 1'b0;
      idx       <= '0;
      bitCnt    <= '0;
      done      <= 1'b0;
    end else begin
      state     <= nState;
      scriptSel <= nSel;
      idx       <= nIdx;
      bitCnt    <= nBit;
      done      <= doneNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tickCnt <= '0;
    else if (restart) tickCnt <= '0;
    else if (tick)    tickCnt <= tickCnt + 1'b1;
  end

  // R10: the chosen script cannot change while one is running
  p_script_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(scriptSel));

  // R11: a tie between both requests selects power-down
  p_down_priority_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startUp && startDown) |=> (scriptSel && busy));

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/pnl_dp.sv
module pnl_dp
  import pnl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pnl_strb_t   strb,
  input  logic [15:0] frameWord,
  output logic        csN,
  output logic        sclOut,
  output logic        sdaOut
);
  logic [15:0] shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg  <= '0;
      csN    <= 1'b1;
      sclOut <= 1'b1;
      sdaOut <= 1'b0;
    end else begin
      if (strb.load) begin
        shreg  <= frameWord;
        sdaOut <= 1'b0;
      end
      if (strb.csLow) csN <= 1'b0;
      if (strb.sclLow) begin
        sclOut <= 1'b0;
        sdaOut <= shreg[15];
      end
      if (strb.sclHigh) begin
        sclOut <= 1'b1;
        shreg  <= {shreg[14:0], 1'b0};
      end
      if (strb.csHigh) begin
        csN    <= 1'b1;
        sdaOut <= 1'b0;
      end
    end
  end

  // R4: data holds while the clock is high inside a frame
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && !csN && $past(sclOut) && !$past(csN)) |-> $stable(sdaOut));

  // R2: the clock only rises with the select active
  p_rise_in_frame_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOut) |-> !csN);
endmodule

// File: rtl/pnl_cmd_seq.sv
module pnl_cmd_seq
  import pnl_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 100,
  parameter int unsigned SETUP_US    = 25,
  parameter int unsigned HALF_US     = 25,
  parameter int unsigned GAP_US      = 100,
  parameter logic [7:0]  MODE_CODE   = 8'hC9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_up,
  input  logic start_down,
  output logic sel_n,
  output logic sclk,
  output logic sdat,
  output logic busy,
  output logic done
);
  logic        tick;
  logic        restart;
  pnl_strb_t   strb;
  logic [15:0] frameWord;

  pnl_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rstN(rst_n), .restart(restart), .tick(tick));

  pnl_ctrl #(.SETUP_US(SETUP_US), .HALF_US(HALF_US), .GAP_US(GAP_US)) u_ctrl (
    .clk(clk), .rstN(rst_n), .startUp(start_up), .startDown(start_down),
    .tick(tick), .restart(restart), .strb(strb), .frameWord(frameWord),
    .busy(busy), .done(done));

  pnl_dp u_dp (
    .clk(clk), .rstN(rst_n), .strb(strb), .frameWord(frameWord),
    .csN(sel_n), .sclOut(sclk), .sdaOut(sdat));

  // R1: idle pin levels
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sel_n && sclk && !sdat));

  // R5: select is active only during a script
  p_sel_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> busy);

  // R9: done marks the end of busy
  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8: the mode code never enters the shifter
  p_no_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |-> (frameWord[15:8] != MODE_CODE && frameWord[7:0] != MODE_CODE));
endmodule

// File: tb/pnl_cmd_seq_bench.sv
module pnl_cmd_seq_bench;
  localparam int C  = 2;
  localparam int SU = 5;
  localparam int HU = 3;
  localparam int GU = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_up = 1'b0;
  logic start_down = 1'b0;
  logic sel_n, sclk, sdat, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pnl_cmd_seq #(.CLKS_PER_US(C), .SETUP_US(SU), .HALF_US(HU), .GAP_US(GU))
    u_pnl_cmd_seq (.clk(clk), .rst_n(rst_n), .start_up(start_up), .start_down(start_down),
                   .sel_n(sel_n), .sclk(sclk), .sdat(sdat), .busy(busy), .done(done));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] expWord(input bit down, input int i);
    logic [15:0] t [5] = '{16'h051E, 16'h05C6, 16'h078D, 16'h1301, 16'h05C7};
    return down ? 16'h055E : t[i];
  endfunction

  // pin monitor
  logic [15:0] frames [$];
  logic prevCs = 1'b1, prevScl = 1'b1, prevBusy = 1'b0;
  int tCsFall = 0, tCsRise = -100000, tSclFall = 0, tSclRise = 0;
  int bitN = 0;
  int doneCnt = 0;
  logic [15:0] cur = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prevCs && !sel_n) begin
        check(cyc - tCsRise >= GU * C, "R5 gap", cyc - tCsRise, GU * C);
        tCsFall = cyc; bitN = 0; cur = '0;
      end
      if (prevScl && !sclk) begin
        if (bitN == 0) check(cyc - tCsFall == SU * C, "R3 setup", cyc - tCsFall, SU * C);
        else check(cyc - tSclRise == HU * C, "R4 high", cyc - tSclRise, HU * C);
        tSclFall = cyc;
      end
      if (!prevScl && sclk) begin
        check(cyc - tSclFall == HU * C, "R4 low", cyc - tSclFall, HU * C);
        check(!sel_n, "R2 rise in frame", sel_n, 0);
        cur = {cur[14:0], sdat}; bitN++; tSclRise = cyc;
      end
      if (!prevCs && sel_n) begin
        check(bitN == 16, "R2 bits", bitN, 16);
        check(cyc - tSclRise == HU * C, "R5 close", cyc - tSclRise, HU * C);
        check(cur[15:8] != 8'hC9 && cur[7:0] != 8'hC9, "R8 mode", cur, 0);
        frames.push_back(cur); tCsRise = cyc;
      end
      if (!busy && !(sel_n && sclk && !sdat)) check(0, "R1 idle pins", {sel_n, sclk, sdat}, 3'b110);
      if (done) begin
        doneCnt++;
        check(!busy && prevBusy, "R9 done at busy end", {busy, prevBusy}, 2'b01);
      end
    end
    prevCs = sel_n; prevScl = sclk; prevBusy = busy;
  end

  // kind: 0 up, 1 down, 2 both; noise: stray pulses while busy
  task automatic runScript(input int kind, input int noise, input string tag);
    int d0;
    bit down;
    int n;
    down = (kind != 0);
    frames.delete();
    d0 = doneCnt;
    @(negedge clk);
    start_up = (kind != 1);
    start_down = (kind != 0);
    @(negedge clk);
    start_up = 1'b0; start_down = 1'b0;
    check(busy, {tag, " R9 busy after start"}, busy, 1);
    for (int k = 0; k < noise; k++) begin
      repeat (1 + ($urandom % 150)) @(negedge clk);
      if (busy) begin
        start_up = $urandom % 2; start_down = $urandom % 2;
        @(negedge clk);
        start_up = 1'b0; start_down = 1'b0;
      end
    end
    while (doneCnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    n = down ? 1 : 5;
    check(doneCnt == d0 + 1, {tag, " R9 one done"}, doneCnt - d0, 1);
    check(frames.size() == n, {tag, " R10 frame count"}, frames.size(), n);
    for (int i = 0; i < frames.size() && i < n; i++)
      check(frames[i] == expWord(down, i),
            {tag, down ? " R7 word" : " R6 word", kind == 2 ? " R11" : ""},
            frames[i], expWord(down, i));
    check(!busy && sel_n, {tag, " R1 idle after"}, {busy, sel_n}, 2'b01);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (2) @(negedge clk);
    check(sel_n && sclk && !sdat && !busy && !done, "R1 in reset",
          {sel_n, sclk, sdat, busy, done}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sel_n && sclk && !sdat && !busy, "R1 after reset", {sel_n, sclk, sdat, busy}, 4'b1100);
    runScript(0, 0, "R6 R12 up");
    runScript(1, 0, "R7 down");
    runScript(2, 0, "R11 both");
    runScript(0, 6, "R10 up noisy");
    runScript(1, 2, "R10 down noisy");
    for (int r = 0; r < 8; r++) begin
      repeat ($urandom % 20) @(negedge clk);
      runScript($urandom % 3, $urandom % 4, "rand");
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule